// File: doc/BRIEF.md
# Programmable External Interrupt Sense Controller

This block sits between a set of external interrupt pins plus a bank of pin-controller interrupt lines and an upstream interrupt controller. Every input first passes through a two-flop synchroniser. A detector then turns it into an active-high level request, and a 2-bit sense code chosen per input sets how the detector works. Software programs the sense codes and the pin-controller enables through a small 32-bit register bus. The bus has a single write strobe and a combinational read port.

The external pins have a sticky status register. In the edge modes a status bit stays set until software acknowledges it. Software does this by writing 0 to the bit while the bit reads 1. All other writes to a status bit are ignored: writes of 1, writes to a bit that is already 0, and any write while that pin is in low-level mode. In low-level mode the status tracks the pin. The pin-controller inputs have no status register. In level modes each request follows the pin, and in edge modes it is a one-cycle pulse. A request is raised only when the input's enable bit is set.

Top module: `ext_irq_sense_ctrl`

## Requirements
- R1: After reset every status bit, request output, type register and enable bit is 0.
- R2: External pin n in type code 0 (low level) has status bit n and irq_req[n] equal to the inverse of the pin. A pin change shows at the third rising clock edge after it.
- R3: External pin n takes its type from bits [2n+1:2n] of offset 0x14. Code 1 latches status on a falling edge, code 2 on a rising edge and code 3 on either edge. The status is readable at bits [7:0] of offset 0x10 and drives irq_req[n].
- R4: In an edge mode, writing 0 to status bit n at offset 0x10 while it reads 1 clears it from the next edge on. Writing 1 leaves the bit unchanged.
- R5: A write to a status bit that reads 0, or to any status bit whose pin is in low-level mode, has no effect.
- R6: When a detected edge and a clearing write arrive in the same cycle, the status bit stays set.
- R7: Pin-controller input k takes its type from offset 0x24 (k < 16) or 0x28 (k >= 16), bits [2f+1:2f] with f = k mod 16. Code 0 = rising edge and 1 = falling edge, each giving a one-cycle request pulse. Code 2 = high level and 3 = low level, each giving a request that follows the pin.
- R8: The enable of input k is bit 8j+7 of offset 0x30+4i, where k = 4i+j. With the enable at 0, tint_req[k] stays 0.
- R9: Changing a type code while the pin is static produces no status set and no request pulse.
- R10: The type and enable registers read back the stored fields at their offsets. Bits that are not stored read 0, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_pin | input | 8 | External interrupt pins |
| tint_pin | input | 32 | Pin-controller interrupt lines |
| irq_req | output | 8 | Level requests from the external pins |
| tint_req | output | 32 | Level requests from the pin-controller lines |

## Verification
A pin change reaches a status bit or request at the third rising edge after it. The bench drives pins at a falling edge and samples at falling edges. It confirms the output is unchanged at the second sample and set at the third. A register write takes effect at the edge inside the write task, so a clear is seen at the next falling edge. A changed type or enable alters a level request one edge later. A rising or falling edge pulse is checked as high at exactly one sample and low at the next. The simultaneous set-and-clear case is timed so the clearing write is on the bus at the same edge that detects the pin's edge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        IRQ_LOW  = 2'd0,
        IRQ_FALL = 2'd1,
        IRQ_RISE = 2'd2,
        IRQ_BOTH = 2'd3
    } irq_sense_e;

    typedef enum logic [1:0] {
        TS_RISE = 2'd0,
        TS_FALL = 2'd1,
        TS_HIGH = 2'd2,
        TS_LOW  = 2'd3
    } tint_sense_e;

    localparam int OFF_IRQ_STAT  = 'h10;
    localparam int OFF_IRQ_TYPE  = 'h14;
    localparam int OFF_TINT_TYPE = 'h24;
    localparam int OFF_TINT_EN   = 'h30;

    localparam int FIELDS_PER_TYPE_REG = 16;
    localparam int INPUTS_PER_EN_REG   = 4;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int   W       = 8,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{{W{RST_VAL}}}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
module irq_detect
    import ext_irq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   sync_i,
    input  logic [2*N-1:0] mode_i,
    input  logic           clr_wr_i,
    input  logic [N-1:0]   clr_data_i,
    output logic [N-1:0]   status_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] status;
    } det_t;

    det_t cur_q, nxt_d;
    logic [N-1:0] hit, clr_ok, is_low;

    always_comb begin
        for (int n = 0; n < N; n++) begin
            is_low[n] = (mode_i[2*n +: 2] == IRQ_LOW);
            unique case (mode_i[2*n +: 2])
                IRQ_FALL: hit[n] = cur_q.prev[n] & ~sync_i[n];
                IRQ_RISE: hit[n] = ~cur_q.prev[n] & sync_i[n];
                IRQ_BOTH: hit[n] = cur_q.prev[n] ^ sync_i[n];
                default:  hit[n] = 1'b0;
            endcase
            clr_ok[n] = clr_wr_i & ~clr_data_i[n] & cur_q.status[n] & ~is_low[n];
        end
    end

    always_comb begin
        nxt_d = cur_q;
        nxt_d.prev = sync_i;
        for (int n = 0; n < N; n++) begin
            if (is_low[n]) begin
                nxt_d.status[n] = ~sync_i[n];
            end else begin
                // a fresh edge outranks a clear in the same cycle
                nxt_d.status[n] = (cur_q.status[n] & ~clr_ok[n]) | hit[n];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.prev   <= '1;
            cur_q.status <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign status_o = cur_q.status;

    for (genvar g = 0; g < N; g++) begin : g_chk
        p_level_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i[2*g +: 2] == IRQ_LOW) |=> (status_o[g] == !$past(sync_i[g])));
        p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ((mode_i[2*g +: 2] != IRQ_LOW) && status_o[g] &&
             !(clr_wr_i && !clr_data_i[g])) |=> status_o[g]);
    end
endmodule

// File: rtl/tint_detect.sv
module tint_detect
    import ext_irq_pkg::*;
#(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   sync_i,
    input  logic [2*N-1:0] mode_i,
    input  logic [N-1:0]   en_i,
    output logic [N-1:0]   req_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] req;
    } td_t;

    td_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        nxt_d.prev = sync_i;
        for (int k = 0; k < N; k++) begin
            unique case (mode_i[2*k +: 2])
                TS_RISE: nxt_d.req[k] = en_i[k] & ~cur_q.prev[k] & sync_i[k];
                TS_FALL: nxt_d.req[k] = en_i[k] & cur_q.prev[k] & ~sync_i[k];
                TS_HIGH: nxt_d.req[k] = en_i[k] & sync_i[k];
                default: nxt_d.req[k] = en_i[k] & ~sync_i[k];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_o = cur_q.req;

    for (genvar g = 0; g < N; g++) begin : g_chk
        p_tint_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !en_i[g] |=> !req_o[g]);
        p_tint_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ((mode_i[2*g +: 2] == TS_RISE || mode_i[2*g +: 2] == TS_FALL) &&
             $stable(mode_i[2*g +: 2]) && req_o[g]) |=> !req_o[g]);
    end
endmodule

// File: rtl/ext_irq_sense_ctrl.sv
module ext_irq_sense_ctrl
    import ext_irq_pkg::*;
#(
    parameter int NUM_IRQ  = 8,
    parameter int NUM_TINT = 32,
    parameter int AW       = 8,
    parameter int DW       = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [NUM_IRQ-1:0]  irq_pin,
    input  logic [NUM_TINT-1:0] tint_pin,
    output logic [NUM_IRQ-1:0]  irq_req,
    output logic [NUM_TINT-1:0] tint_req
);
    localparam int N_TYPE_REGS = (NUM_TINT + FIELDS_PER_TYPE_REG - 1) / FIELDS_PER_TYPE_REG;
    localparam int N_EN_REGS   = (NUM_TINT + INPUTS_PER_EN_REG - 1) / INPUTS_PER_EN_REG;
    localparam int EN_LANE     = DW / INPUTS_PER_EN_REG;

    typedef struct packed {
        logic [2*NUM_IRQ-1:0]  irq_type;
        logic [2*NUM_TINT-1:0] tint_type;
        logic [NUM_TINT-1:0]   tint_en;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    logic [NUM_IRQ-1:0]  irq_sync, irq_status;
    logic [NUM_TINT-1:0] tint_sync;
    logic                clr_wr;

    always_comb begin
        cfg_d = cfg_q;
        if (bus_we) begin
            if (bus_addr == AW'(OFF_IRQ_TYPE)) begin
                cfg_d.irq_type = bus_wdata[2*NUM_IRQ-1:0];
            end
            for (int r = 0; r < N_TYPE_REGS; r++) begin
                if (bus_addr == AW'(OFF_TINT_TYPE + 4*r)) begin
                    for (int f = 0; f < FIELDS_PER_TYPE_REG; f++) begin
                        if (r*FIELDS_PER_TYPE_REG + f < NUM_TINT) begin
                            cfg_d.tint_type[2*(r*FIELDS_PER_TYPE_REG+f) +: 2] = bus_wdata[2*f +: 2];
                        end
                    end
                end
            end
            for (int r = 0; r < N_EN_REGS; r++) begin
                if (bus_addr == AW'(OFF_TINT_EN + 4*r)) begin
                    for (int j = 0; j < INPUTS_PER_EN_REG; j++) begin
                        if (r*INPUTS_PER_EN_REG + j < NUM_TINT) begin
                            cfg_d.tint_en[r*INPUTS_PER_EN_REG+j] = bus_wdata[EN_LANE*j + EN_LANE-1];
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFF_IRQ_STAT)) begin
            bus_rdata[NUM_IRQ-1:0] = irq_status;
        end
        if (bus_addr == AW'(OFF_IRQ_TYPE)) begin
            bus_rdata[2*NUM_IRQ-1:0] = cfg_q.irq_type;
        end
        for (int r = 0; r < N_TYPE_REGS; r++) begin
            if (bus_addr == AW'(OFF_TINT_TYPE + 4*r)) begin
                for (int f = 0; f < FIELDS_PER_TYPE_REG; f++) begin
                    if (r*FIELDS_PER_TYPE_REG + f < NUM_TINT) begin
                        bus_rdata[2*f +: 2] = cfg_q.tint_type[2*(r*FIELDS_PER_TYPE_REG+f) +: 2];
                    end
                end
            end
        end
        for (int r = 0; r < N_EN_REGS; r++) begin
            if (bus_addr == AW'(OFF_TINT_EN + 4*r)) begin
                for (int j = 0; j < INPUTS_PER_EN_REG; j++) begin
                    if (r*INPUTS_PER_EN_REG + j < NUM_TINT) begin
                        bus_rdata[EN_LANE*j + EN_LANE-1] = cfg_q.tint_en[r*INPUTS_PER_EN_REG+j];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign clr_wr = bus_we && (bus_addr == AW'(OFF_IRQ_STAT));

    eirq_sync #(.W(NUM_IRQ), .STAGES(2), .RST_VAL(1'b1)) u_irq_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (irq_pin),
        .q_o   (irq_sync)
    );

    eirq_sync #(.W(NUM_TINT), .STAGES(2), .RST_VAL(1'b0)) u_tint_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (tint_pin),
        .q_o   (tint_sync)
    );

    irq_detect #(.N(NUM_IRQ)) u_irq_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (irq_sync),
        .mode_i     (cfg_q.irq_type),
        .clr_wr_i   (clr_wr),
        .clr_data_i (bus_wdata[NUM_IRQ-1:0]),
        .status_o   (irq_status)
    );

    tint_detect #(.N(NUM_TINT)) u_tint_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (tint_sync),
        .mode_i (cfg_q.tint_type),
        .en_i   (cfg_q.tint_en),
        .req_o  (tint_req)
    );

    assign irq_req = irq_status;

    p_req_is_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(OFF_IRQ_STAT)) |-> (bus_rdata[NUM_IRQ-1:0] == irq_req));
endmodule

// File: tb/ext_irq_sense_ctrl_bench.sv
`timescale 1ns/1ps
module ext_irq_sense_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_pin = '1;
    logic [31:0] tint_pin = '0;
    logic [7:0]  irq_req;
    logic [31:0] tint_req;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    ext_irq_sense_ctrl u_ext_irq_sense_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pin(irq_pin),
        .tint_pin(tint_pin), .irq_req(irq_req), .tint_req(tint_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h10, v); check("R1 status", v, 0);
        rd(8'h14, v); check("R1 irq type", v, 0);
        rd(8'h24, v); check("R1 tint type0", v, 0);
        rd(8'h30, v); check("R1 enable0", v, 0);
        check("R1 irq_req", {24'd0, irq_req}, 0);
        check("R1 tint_req", tint_req, 0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(8'h14, 32'hFFFF_A5A5); rd(8'h14, v); check("R10 irq type", v, 32'h0000_A5A5);
        wr(8'h28, 32'h1234_5678); rd(8'h28, v); check("R10 tint type1", v, 32'h1234_5678);
        wr(8'h3C, 32'hFFFF_FFFF); rd(8'h3C, v); check("R10 enable3", v, 32'h8080_8080);
        rd(8'h20, v); check("R10 unmapped", v, 0);
        wr(8'h14, 0); wr(8'h28, 0); wr(8'h3C, 0);
        rd(8'h28, v); check("R10 restore", v, 0);
    endtask

    task automatic t_irq_level();
        logic [31:0] v;
        irq_pin[2] = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 not yet", {24'd0, irq_req}, 0);
        @(negedge clk);
        check("R2 low level req", {24'd0, irq_req}, 32'h4);
        wr(8'h10, 32'h0);
        rd(8'h10, v); check("R5 level write ignored", v, 32'h4);
        irq_pin[2] = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 released", {24'd0, irq_req}, 0);
    endtask

    task automatic t_irq_edges();
        logic [31:0] v;
        wr(8'h14, 32'h0000_00C9);
        wr(8'h10, 32'h0);
        rd(8'h10, v); check("R5 idle write ignored", v, 0);
        irq_pin[0] = 1'b0; irq_pin[1] = 1'b0; irq_pin[3] = 1'b0;
        repeat (3) @(negedge clk);
        rd(8'h10, v); check("R3 falling/both", v, 32'h09);
        irq_pin[0] = 1'b1; irq_pin[1] = 1'b1; irq_pin[3] = 1'b1;
        repeat (3) @(negedge clk);
        rd(8'h10, v); check("R3 rising sticky", v, 32'h0B);
        wr(8'h10, 32'hFF);
        rd(8'h10, v); check("R4 write one no effect", v, 32'h0B);
        wr(8'h10, 32'hFE);
        rd(8'h10, v); check("R4 clear bit0", v, 32'h0A);
        check("R4 req follows", {24'd0, irq_req}, 32'h0A);
        wr(8'h10, 32'h00);
        rd(8'h10, v); check("R4 clear all", v, 0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        irq_pin[3] = 1'b0;
        repeat (3) @(negedge clk);
        rd(8'h10, v); check("R6 setup", v, 32'h08);
        irq_pin[3] = 1'b1;
        repeat (2) @(negedge clk);
        wr(8'h10, 32'h00);
        rd(8'h10, v); check("R6 set beats clear", v, 32'h08);
        wr(8'h10, 32'h00);
        rd(8'h10, v); check("R6 later clear", v, 0);
        wr(8'h14, 0);
    endtask

    task automatic t_mode_switch();
        logic [31:0] v;
        int bad = 0;
        wr(8'h14, 32'h0000_0200);
        repeat (5) @(negedge clk);
        rd(8'h10, v); check("R9 irq switch", v, 0);
        wr(8'h14, 0);
        tint_pin[5] = 1'b1;
        repeat (4) @(negedge clk);
        wr(8'h34, 32'h0000_8000);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); if (tint_req != 0) bad++;
        end
        wr(8'h24, 32'h0000_0400);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); if (tint_req != 0) bad++;
        end
        check("R9 no pulse on switch", bad, 0);
        tint_pin[5] = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 fall not yet", tint_req, 0);
        @(negedge clk);
        check("R7 fall pulse k5", tint_req, 32'h20);
        @(negedge clk);
        check("R7 pulse one cycle", tint_req, 0);
        wr(8'h34, 0); wr(8'h24, 0);
    endtask

    task automatic t_tint();
        wr(8'h24, 32'h0000_0080);
        wr(8'h30, 32'h8000_0000);
        tint_pin[3] = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 high not yet", tint_req, 0);
        @(negedge clk);
        check("R7 high level", tint_req, 32'h8);
        tint_pin[3] = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 high released", tint_req, 0);
        wr(8'h28, 32'h0000_0300);
        wr(8'h44, 32'h0000_0080);
        @(negedge clk);
        check("R7 low level k20", tint_req, 32'h0010_0000);
        wr(8'h44, 0);
        @(negedge clk);
        check("R8 disable drops", tint_req, 0);
        wr(8'h28, 0);
    endtask

    task automatic t_gate();
        int bad = 0;
        wr(8'h30, 0);
        tint_pin[3] = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); if (tint_req != 0) bad++;
        end
        check("R8 disabled no req", bad, 0);
        wr(8'h30, 32'h8000_0000);
        @(negedge clk);
        check("R8 enabled req", tint_req, 32'h8);
        wr(8'h30, 0); tint_pin[3] = 1'b0;
        wr(8'h24, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_readback();
        t_irq_level();
        t_irq_edges();
        t_set_wins();
        t_mode_switch();
        t_tint();
        t_gate();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule